// File: doc/BRIEF.md
# Scan-Cycle Ladder Rung Evaluator

This block behaves like a very small programmable logic controller that runs one fixed ladder program again and again. Each pass, called a scan, does three things in order. It freezes the eight input pins into an input image. It then works through six hard-wired rungs, one rung per clock, and writes each result into a coil image. Last, it copies the coil image onto the eight output pins and pulses a done flag for one cycle.

The program contains three combinational rungs and a motor latch. The latch has a start contact, a normally-closed stop contact and a seal-in contact that reads the motor's own coil. Two indicator lamps follow the motor. The rungs run in a fixed order, so the lamp rungs see the motor value that this same scan has just computed. The motor rung sees the motor value from the previous scan. A scan starts only when the scan-enable input is high while the block waits between scans.

Input bit map: bit0 A, bit1 B, bit2 C, bit3 D, bit4 SW1, bit5 SW2, bit6 START, bit7 STOP. Output bit map: bit0 X, bit1 Y, bit2 LAMP, bit3 MOTOR, bit4 GREEN, bit5 RED, bits 7:6 spare.

Top module: `ladder_scan`

## Requirements
- R1: While reset (rst_n = 0) is asserted, out_pins is 8'h00 and scan_done is 0, and the motor coil is cleared, so the motor is stopped.
- R2: If scan_en is high on a clock edge while the block is waiting, that edge captures in_pins. scan_done goes high for exactly one cycle after the 7th edge that follows the capture edge. While scan_en stays high, scans repeat every 8 cycles. While scan_en stays low, no scan starts.
- R3: Every result of a scan depends only on the in_pins value captured at that scan's capture edge. Changes to in_pins during the rest of the scan have no effect.
- R4: out_pins changes only on the edge that raises scan_done. At all other times it holds its value.
- R5: out bit0 X = (A OR B) AND (C OR D).
- R6: out bit1 Y = (NOT A) AND (B OR (C AND D)).
- R7: out bit2 LAMP = SW1 OR SW2.
- R8: out bit3 MOTOR is set by a scan that sees START = 1 and STOP = 0. Later scans keep it set through its own coil after START returns to 0.
- R9: A scan that sees STOP = 1 clears MOTOR, even when START is also 1.
- R10: out bit4 GREEN equals MOTOR and out bit5 RED equals NOT MOTOR, using the MOTOR value written by the same scan.
- R11: Spare output bits 7:6 are always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_en | input | 1 | Allows a new scan to start |
| in_pins | input | 8 | Field inputs (A, B, C, D, SW1, SW2, START, STOP) |
| out_pins | output | 8 | Field outputs (X, Y, LAMP, MOTOR, GREEN, RED, spare) |
| scan_done | output | 1 | One-cycle pulse when out_pins is updated |

## Verification
A wrong rung index or phase shows up at the ports at the next scan_done. It appears either as a misplaced pulse or as a wrong output field, and a rung that reads the wrong image bits gives a wrong bit in that same scan. A corrupted coil image is slower to expose, because the motor seal-in only shows it one scan later. For that reason the stimulus sequence sets the latch, releases start, and then applies stop with and without start. The bench drives the inverse of each captured input during the evaluate cycles, so any late sampling turns into a wrong output.

// File: rtl/ladder_pkg.sv
package ladder_pkg;

    typedef enum logic [1:0] {
        PH_WAIT  = 2'd0,
        PH_EVAL  = 2'd1,
        PH_WRITE = 2'd2
    } phase_e;

    localparam int N_RUNGS = 6;
    localparam int RUNG_W  = $clog2(N_RUNGS);

    // input image bit positions
    localparam int I_A     = 0;
    localparam int I_B     = 1;
    localparam int I_C     = 2;
    localparam int I_D     = 3;
    localparam int I_SW1   = 4;
    localparam int I_SW2   = 5;
    localparam int I_START = 6;
    localparam int I_STOP  = 7;
    localparam int I_USED  = 8;

    // coil / output image bit positions
    localparam int O_X     = 0;
    localparam int O_Y     = 1;
    localparam int O_LAMP  = 2;
    localparam int O_MOTOR = 3;
    localparam int O_GREEN = 4;
    localparam int O_RED   = 5;
    localparam int O_USED  = 6;

    // rung execution order
    localparam int RG_X     = 0;
    localparam int RG_Y     = 1;
    localparam int RG_LAMP  = 2;
    localparam int RG_MOTOR = 3;
    localparam int RG_GREEN = 4;
    localparam int RG_RED   = 5;

endpackage

// File: rtl/ladder_seq.sv
module ladder_seq
    import ladder_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scan_en,
    output logic              capture,
    output logic              eval_en,
    output logic              write_en,
    output logic [RUNG_W-1:0] rung,
    output logic              done
);

    typedef struct packed {
        phase_e              phase;
        logic [RUNG_W-1:0]   rung;
        logic                done;
    } seq_t;

    seq_t seq_d, seq_q;

    localparam logic [RUNG_W-1:0] LAST_RUNG = RUNG_W'(N_RUNGS - 1);

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        unique case (seq_q.phase)
            PH_WAIT: begin
                if (scan_en) begin
                    seq_d.phase = PH_EVAL;
                    seq_d.rung  = '0;
                end
            end
            PH_EVAL: begin
                if (seq_q.rung == LAST_RUNG) begin
                    seq_d.phase = PH_WRITE;
                end else begin
                    seq_d.rung = seq_q.rung + 1'b1;
                end
            end
            PH_WRITE: begin
                seq_d.phase = PH_WAIT;
                seq_d.done  = 1'b1;
            end
            default: seq_d.phase = PH_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{phase: PH_WAIT, rung: '0, done: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign capture  = (seq_q.phase == PH_WAIT) && scan_en;
    assign eval_en  = (seq_q.phase == PH_EVAL);
    assign write_en = (seq_q.phase == PH_WRITE);
    assign rung     = seq_q.rung;
    assign done     = seq_q.done;

endmodule

// File: rtl/ladder_rungs.sv
module ladder_rungs
    import ladder_pkg::*;
#(
    parameter int IN_W  = 8,
    parameter int OUT_W = 8
) (
    input  logic [RUNG_W-1:0] rung,
    input  logic [IN_W-1:0]   in_img,
    input  logic [OUT_W-1:0]  coil_img,
    output logic [OUT_W-1:0]  coil_next
);

    logic a, b, c, d, sw1, sw2, start_c, stop_c;

    assign a       = in_img[I_A];
    assign b       = in_img[I_B];
    assign c       = in_img[I_C];
    assign d       = in_img[I_D];
    assign sw1     = in_img[I_SW1];
    assign sw2     = in_img[I_SW2];
    assign start_c = in_img[I_START];
    assign stop_c  = in_img[I_STOP];

    always_comb begin
        coil_next = coil_img;
        unique case (int'(rung))
            RG_X:     coil_next[O_X]     = (a | b) & (c | d);
            RG_Y:     coil_next[O_Y]     = ~a & (b | (c & d));
            RG_LAMP:  coil_next[O_LAMP]  = sw1 | sw2;
            // seal-in branch in parallel with start, stop contact normally closed
            RG_MOTOR: coil_next[O_MOTOR] = (start_c | coil_img[O_MOTOR]) & ~stop_c;
            RG_GREEN: coil_next[O_GREEN] = coil_img[O_MOTOR];
            RG_RED:   coil_next[O_RED]   = ~coil_img[O_MOTOR];
            default:  coil_next = coil_img;
        endcase
    end

endmodule

// File: rtl/ladder_scan.sv
module ladder_scan
    import ladder_pkg::*;
#(
    parameter int IN_W  = 8,
    parameter int OUT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scan_en,
    input  logic [IN_W-1:0]  in_pins,
    output logic [OUT_W-1:0] out_pins,
    output logic             scan_done
);

    localparam int SPARE_W = OUT_W - O_USED;

    typedef struct packed {
        logic [IN_W-1:0]  in_img;
        logic [OUT_W-1:0] coil_img;
        logic [OUT_W-1:0] out_img;
    } img_t;

    img_t img_d, img_q;

    logic              capture, eval_en, write_en;
    logic [RUNG_W-1:0] rung;
    logic [OUT_W-1:0]  coil_next;
    logic [IN_W-1:0]   in_img_q;

    ladder_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .scan_en  (scan_en),
        .capture  (capture),
        .eval_en  (eval_en),
        .write_en (write_en),
        .rung     (rung),
        .done     (scan_done)
    );

    ladder_rungs #(.IN_W(IN_W), .OUT_W(OUT_W)) u_rungs (
        .rung      (rung),
        .in_img    (img_q.in_img),
        .coil_img  (img_q.coil_img),
        .coil_next (coil_next)
    );

    always_comb begin
        img_d = img_q;
        if (capture) begin
            img_d.in_img = in_pins;
        end
        if (eval_en) begin
            img_d.coil_img = coil_next;
            if (SPARE_W > 0) begin
                img_d.coil_img[OUT_W-1:O_USED] = '0;
            end
        end
        if (write_en) begin
            img_d.out_img = img_q.coil_img;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            img_q <= '0;
        end else begin
            img_q <= img_d;
        end
    end

    assign out_pins = img_q.out_img;
    assign in_img_q = img_q.in_img;

endmodule

// File: rtl/ladder_scan_chk.sv
module ladder_scan_chk
    import ladder_pkg::*;
#(
    parameter int IN_W  = 8,
    parameter int OUT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [OUT_W-1:0] out_pins,
    input logic             scan_done,
    input logic [IN_W-1:0]  in_img
);

    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |=> !scan_done);

    assert_out_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_pins) |-> scan_done);

    assert_x_rung_R5: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |-> out_pins[O_X] == ((in_img[I_A] | in_img[I_B]) & (in_img[I_C] | in_img[I_D])));

    assert_start_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_done && in_img[I_START] && !in_img[I_STOP]) |-> out_pins[O_MOTOR]);

    assert_stop_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_done && in_img[I_STOP]) |-> !out_pins[O_MOTOR]);

    assert_lamps_R10: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |-> (out_pins[O_GREEN] == out_pins[O_MOTOR]) && (out_pins[O_RED] != out_pins[O_MOTOR]));

    assert_spare_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_pins >> O_USED) == '0);

endmodule

bind ladder_scan ladder_scan_chk #(.IN_W(IN_W), .OUT_W(OUT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_pins  (out_pins),
    .scan_done (scan_done),
    .in_img    (in_img_q)
);

// File: tb/tb_ladder_scan.sv
module tb_ladder_scan;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scan_en = 1'b0;
    logic [7:0] in_pins = 8'h00;
    logic [7:0] out_pins;
    logic       scan_done;

    int checks = 0;
    int errors = 0;
    bit ended  = 1'b0;

    always #5 clk = ~clk;

    ladder_scan dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scan_en   (scan_en),
        .in_pins   (in_pins),
        .out_pins  (out_pins),
        .scan_done (scan_done)
    );

    // {stimulus, expected outputs}, applied in order (motor state carries over)
    localparam int NV = 14;
    localparam logic [15:0] VEC [NV] = '{
        16'h00_20, 16'h05_21, 16'h0E_23, 16'h0C_22, 16'h12_26, 16'h20_24,
        16'h40_18, 16'h00_18, 16'hC0_20, 16'h40_18, 16'h80_20, 16'h00_20,
        16'h09_21, 16'h0A_23
    };

    task automatic chk(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // one scan with scan_en pulsed; inverse of stimulus driven after capture
    task automatic run_scan(input logic [7:0] stim, input logic [7:0] exp);
        logic [7:0] prev;
        logic       hold_ok;
        logic       early;
        prev     = out_pins;
        hold_ok  = 1'b1;
        early    = 1'b0;
        in_pins  = stim;
        scan_en  = 1'b1;
        @(negedge clk);
        scan_en  = 1'b0;
        in_pins  = ~stim;
        for (int j = 2; j <= 8; j++) begin
            @(negedge clk);
            if (j < 8) begin
                if (scan_done) early = 1'b1;
                if (out_pins !== prev) hold_ok = 1'b0;
            end
        end
        chk(!early && scan_done === 1'b1, "R2 done timing", {7'b0, scan_done}, 8'h01);
        chk(hold_ok, "R4 outputs held during scan", out_pins, prev);
        chk(out_pins[0] === exp[0], "R5 X rung (R3 frozen image)", out_pins, exp);
        chk(out_pins[1] === exp[1], "R6 Y rung", out_pins, exp);
        chk(out_pins[2] === exp[2], "R7 lamp rung", out_pins, exp);
        chk(out_pins[3] === exp[3], "R8/R9 motor latch", out_pins, exp);
        chk(out_pins[5:4] === exp[5:4], "R10 indicator lamps", out_pins, exp);
        chk(out_pins[7:6] === 2'b00, "R11 spare bits", out_pins, exp);
        @(negedge clk);
        chk(scan_done === 1'b0, "R2 single pulse", {7'b0, scan_done}, 8'h00);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        chk(1'b0, "watchdog", 8'h00, 8'h00);
        finish_run();
    end

    initial begin
        logic       stable;
        logic       seen;
        int         gap;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(out_pins === 8'h00, "R1 reset outputs", out_pins, 8'h00);
        chk(scan_done === 1'b0, "R1 reset done", {7'b0, scan_done}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            run_scan(VEC[v][15:8], VEC[v][7:0]);
        end

        // R2: scan_en low starts nothing, R4 outputs unchanged
        stable = 1'b1;
        seen   = 1'b0;
        in_pins = 8'h40;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (scan_done) seen = 1'b1;
            if (out_pins !== 8'h23) stable = 1'b0;
        end
        chk(!seen, "R2 no scan without enable", {7'b0, seen}, 8'h00);
        chk(stable, "R4 idle outputs held", out_pins, 8'h23);

        // R2: continuous enable repeats every 8 cycles
        scan_en = 1'b1;
        gap = 0;
        while (!scan_done && gap < 20) begin
            @(negedge clk);
            gap++;
        end
        chk(gap == 8, "R2 first scan latency", 8'(gap), 8'd8);
        chk(out_pins === 8'h18, "R8 start via continuous scan", out_pins, 8'h18);
        gap = 0;
        do begin
            @(negedge clk);
            gap++;
        end while (!scan_done && gap < 20);
        chk(gap == 8, "R2 scan period", 8'(gap), 8'd8);
        scan_en = 1'b0;
        in_pins = 8'h00;
        repeat (3) @(negedge clk);

        // R1: reset mid-operation with motor running
        rst_n = 1'b0;
        @(negedge clk);
        chk(out_pins === 8'h00, "R1 reset clears outputs", out_pins, 8'h00);
        chk(scan_done === 1'b0, "R1 reset clears done", {7'b0, scan_done}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        // motor latch cleared by reset: no start gives stopped motor, red lamp
        run_scan(8'h00, 8'h20);
        chk(out_pins === 8'h20, "R1 motor stopped after reset", out_pins, 8'h20);

        finish_run();
    end

endmodule